// File: doc/BRIEF.md
# Base-Relative Load/Store Unit

This block turns one decoded memory access from a thread into a memory transaction. The access can be taken relative to the stack pointer, the data pointer, the constant-pool pointer or a general register, or it can be indexed from two registers. The unit forms the byte address and checks the access against the rules for that form. A legal access drives a single-cycle synchronous memory port. A load returns the addressed byte, halfword or word, zero-extended unless sign extension is requested. An access that breaks the rules raises an exception code and never reaches memory.

Pointer-relative and register-relative forms scale their immediate by four and allow word accesses only. Each short form has its own offset limit. An extended flag widens the limit of every non-indexed form so that it reaches 64 KBytes. Indexed accesses shift the index register left by the size code, so the index counts elements of the access size. A write through the constant-pool pointer is refused.

Control is a four-state machine. ST_IDLE accepts a request. The transition "accept-legal" leads to ST_ACCESS, and "accept-fault" leads to ST_FAULT. ST_ACCESS drives the memory port. From there, "store-done" returns to ST_IDLE and "load-issued" moves to ST_REPLY. ST_REPLY presents the load result and takes "reply-done" back to ST_IDLE. ST_FAULT presents the exception for one cycle and takes "fault-done" back to ST_IDLE.

Top module: `lsu_base_rel`

## Requirements
- R1: After reset, req_ready is 1 and mem_en, rsp_valid and exc_valid are all 0.
- R2: Mode codes 0 (stack), 1 (data) and 2 (constant pool) form the address pointer + 4*imm. The short form accepts imm from 0 to 63 with size code 2 (word).
- R3: Mode code 3 forms the address base_val + 4*imm. The short form accepts imm from 0 to 11 with size code 2 (word).
- R4: Mode code 4 forms the address base_val + (index_val << size). Size codes are 0 byte, 1 halfword and 2 word.
- R5: With req_ext = 1, modes 0 to 3 accept imm from 0 to 16383, so the byte offset reaches 64 KBytes. imm of 16384 is a form fault.
- R6: The following raise exception code 3 (form fault) with no memory access: an imm above the limit of the form, a size other than word in modes 0 to 3, size code 3, req_ext with mode 4, and mode codes 5 to 7.
- R7: A write in mode 2 raises exception code 1 (read-only base) and issues no memory write. Reads in mode 2 are legal.
- R8: A word address with bits [1:0] not 00, or a halfword address with bit 0 set, raises exception code 2 (misaligned) with no access. When several faults apply, code 3 wins over code 1, and code 1 wins over code 2.
- R9: The memory port is driven in the cycle after acceptance. A load result appears with rsp_valid one cycle later. A fault shows exc_valid for exactly the one cycle after acceptance. req_ready is 0 while a request is in progress.
- R10: Writes enable the byte lanes selected by address bits [1:0], little-endian. The write data is placed in every lane: a byte is copied into all four lanes and a halfword into both halves.
- R11: A load returns the addressed bytes shifted down to bit 0, zero-extended when req_sext is 0.
- R12: With req_sext = 1, byte and halfword loads are sign-extended. For word loads the flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_mode | input | 3 | Base form code (0 stack, 1 data, 2 constant, 3 register, 4 indexed) |
| req_ext | input | 1 | Extended offset range |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_sext | input | 1 | Sign-extend narrow loads |
| req_imm | input | 16 | Word offset for non-indexed forms |
| req_wdata | input | 32 | Store data, right-aligned |
| sp_val | input | 32 | Stack pointer value |
| dp_val | input | 32 | Data pointer value |
| cp_val | input | 32 | Constant-pool pointer value |
| base_val | input | 32 | General base register value |
| index_val | input | 32 | Index register value |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the access |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Extended load result |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 1 read-only base, 2 misaligned, 3 form fault |

## Verification
Each base form is tried at its offset limit and one step beyond it. This separates a correct limit from an off-by-one error and shows that each form uses its own limit. Byte writes to each of the four lanes, followed by a word read-back, separate correct lane enables from misplaced ones. A word holding bytes with and without the top bit set is then read by byte and by halfword, with and without sign extension, which tells zero extension from sign extension and shows the correct shift for each lane. Combined faults, such as a constant-pool write that is also out of range or misaligned, show the fault priority, and a read-back after a refused write shows that memory was left untouched.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef enum logic [2:0] {
        MODE_STK = 3'd0,
        MODE_DAT = 3'd1,
        MODE_CON = 3'd2,
        MODE_REG = 3'd3,
        MODE_IDX = 3'd4
    } base_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        EXC_NONE     = 2'd0,
        EXC_RO_WRITE = 2'd1,
        EXC_ALIGN    = 2'd2,
        EXC_FORM     = 2'd3
    } exc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_REPLY,
        ST_FAULT
    } lsu_state_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 16,
    parameter int PTR_LIM = 63,
    parameter int REG_LIM = 11,
    parameter int EXT_LIM = 16383
) (
    input  logic [2:0]        mode,
    input  logic              ext,
    input  logic              write,
    input  logic [1:0]        size,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic [ADDR_W-1:0] dp_val,
    input  logic [ADDR_W-1:0] cp_val,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic [ADDR_W-1:0] addr,
    output exc_e              exc
);
    localparam logic [IMM_W-1:0] PTR_LIM_V = IMM_W'(PTR_LIM);
    localparam logic [IMM_W-1:0] REG_LIM_V = IMM_W'(REG_LIM);
    localparam logic [IMM_W-1:0] EXT_LIM_V = IMM_W'(EXT_LIM);

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] offset;
    logic [IMM_W-1:0]  lim;
    logic              form_bad;
    logic              ro_bad;
    logic              align_bad;

    always_comb begin
        case (mode)
            MODE_STK: base_sel = sp_val;
            MODE_DAT: base_sel = dp_val;
            MODE_CON: base_sel = cp_val;
            default:  base_sel = base_val;
        endcase
        if (mode == MODE_IDX) offset = index_val << size;
        else                  offset = ADDR_W'({imm, 2'b00});
        addr = base_sel + offset;
    end

    always_comb begin
        lim = ext ? EXT_LIM_V : ((mode == MODE_REG) ? REG_LIM_V : PTR_LIM_V);
        if (mode > MODE_IDX)       form_bad = 1'b1;
        else if (mode == MODE_IDX) form_bad = ext || (size == SZ_RSVD);
        else                       form_bad = (size != SZ_WORD) || (imm > lim);
        ro_bad    = (mode == MODE_CON) && write;
        align_bad = ((size == SZ_WORD) && (addr[1:0] != 2'b00)) ||
                    ((size == SZ_HALF) && addr[0]);
        if (form_bad)       exc = EXC_FORM;
        else if (ro_bad)    exc = EXC_RO_WRITE;
        else if (align_bad) exc = EXC_ALIGN;
        else                exc = EXC_NONE;
    end

    always_comb begin
        if (ro_bad && !form_bad) assert_ro_wins_R8: assert (exc == EXC_RO_WRITE);
    end
endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
    import lsu_pkg::*;
(
    input  size_e                 size,
    input  logic                  sext,
    input  logic [LANE_IDX_W-1:0] lane_sel,
    input  logic [WORD_W-1:0]     wdata_in,
    output logic [LANES-1:0]      be,
    output logic [WORD_W-1:0]     wdata_out,
    input  logic [WORD_W-1:0]     rdata,
    output logic [WORD_W-1:0]     load_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata_out[g*8 +: 8] =
            (size == SZ_BYTE) ? wdata_in[7:0] :
            (size == SZ_HALF) ? wdata_in[(g % 2)*8 +: 8] :
                                wdata_in[g*8 +: 8];
        assign be[g] =
            (size == SZ_BYTE) ? (lane_sel == LANE_IDX_W'(g)) :
            (size == SZ_HALF) ? (lane_sel[LANE_IDX_W-1] == 1'(g / 2)) :
                                1'b1;
    end

    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted = rdata >> {lane_sel, 3'b000};
        case (size)
            SZ_BYTE: load_data = {{(WORD_W-8){sext & shifted[7]}}, shifted[7:0]};
            SZ_HALF: load_data = {{(WORD_W-16){sext & shifted[15]}}, shifted[15:0]};
            default: load_data = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_fsm.sv
module lsu_fsm
    import lsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic fault,
    input  logic write_q,
    output logic accept,
    output logic req_ready,
    output logic mem_en,
    output logic mem_we,
    output logic rsp_valid,
    output logic exc_valid
);
    lsu_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = fault ? ST_FAULT : ST_ACCESS;
            ST_ACCESS: state_nx = write_q ? ST_IDLE : ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
            ST_FAULT:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req_ready = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        rsp_valid = 1'b0;
        exc_valid = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_ACCESS: begin
                mem_en = 1'b1;
                mem_we = write_q;
            end
            ST_REPLY:  rsp_valid = 1'b1;
            ST_FAULT:  exc_valid = 1'b1;
        endcase
        accept = req_valid && req_ready;
    end

    assert_load_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> rsp_valid);
    assert_fault_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !mem_en);
    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (!exc_valid && req_ready));
    assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en || rsp_valid) |-> !req_ready);
endmodule

// File: rtl/lsu_base_rel.sv
module lsu_base_rel
    import lsu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 16,
    parameter int PTR_LIM = 63,
    parameter int REG_LIM = 11,
    parameter int EXT_LIM = 16383
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_mode,
    input  logic              req_ext,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_sext,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic [ADDR_W-1:0] dp_val,
    input  logic [ADDR_W-1:0] cp_val,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              exc_valid,
    output logic [1:0]        exc_code
);
    logic [ADDR_W-1:0] addr_now, addr_q;
    exc_e              exc_now, exc_q;
    size_e             size_q;
    logic              sext_q, write_q;
    logic [WORD_W-1:0] wdata_q;
    logic              accept;
    logic [LANES-1:0]  lane_be;
    logic [WORD_W-1:0] load_data;

    lsu_addr_gen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .PTR_LIM(PTR_LIM),
        .REG_LIM(REG_LIM),
        .EXT_LIM(EXT_LIM)
    ) u_agen (
        .mode     (req_mode),
        .ext      (req_ext),
        .write    (req_write),
        .size     (req_size),
        .imm      (req_imm),
        .sp_val   (sp_val),
        .dp_val   (dp_val),
        .cp_val   (cp_val),
        .base_val (base_val),
        .index_val(index_val),
        .addr     (addr_now),
        .exc      (exc_now)
    );

    lsu_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .fault    (exc_now != EXC_NONE),
        .write_q  (write_q),
        .accept   (accept),
        .req_ready(req_ready),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .rsp_valid(rsp_valid),
        .exc_valid(exc_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            exc_q   <= EXC_NONE;
            size_q  <= SZ_WORD;
            sext_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_now;
            exc_q   <= exc_now;
            size_q  <= size_e'(req_size);
            sext_q  <= req_sext;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    lsu_lane u_lane (
        .size     (size_q),
        .sext     (sext_q),
        .lane_sel (addr_q[LANE_IDX_W-1:0]),
        .wdata_in (wdata_q),
        .be       (lane_be),
        .wdata_out(mem_wdata),
        .rdata    (mem_rdata),
        .load_data(load_data)
    );

    assign mem_addr = addr_q;
    assign mem_be   = mem_en ? lane_be : '0;
    assign rsp_data = rsp_valid ? load_data : '0;
    assign exc_code = exc_valid ? exc_q : EXC_NONE;

    assert_con_write_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == 3'd2 && req_write && req_size == 2'd2 && !req_ext &&
         req_imm <= IMM_W'(PTR_LIM)) |=> (exc_valid && exc_code == 2'd1 && !mem_en));
    assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && size_q == SZ_WORD) |-> (mem_addr[1:0] == 2'b00));
    assert_byte_one_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && size_q == SZ_BYTE) |-> ($countones(mem_be) == 1));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_en && !rsp_valid && !exc_valid));
endmodule

// File: tb/sim_lsu_base_rel.sv
module sim_lsu_base_rel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_mode = '0;
    logic        req_ext = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic        req_sext = 1'b0;
    logic [15:0] req_imm = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] sp_val = 32'h100, dp_val = 32'h200, cp_val = 32'h300;
    logic [31:0] base_val = '0, index_val = '0;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, rsp_data;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, exc_valid;
    logic [1:0]  exc_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lsu_base_rel u0 (.*);

    logic [31:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 32'h8000_0000 ^ (i * 32'h0103_0507);

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] mode, input logic ext, input logic wr,
                          input logic [1:0] size, input logic sx, input logic [15:0] imm,
                          input logic [31:0] bv, input logic [31:0] iv, input logic [31:0] wd,
                          input string tag);
        logic [31:0] a, w, exp_rd, exp_wd;
        logic [3:0]  exp_be;
        int code, lim, sh;
        code = 0;
        if (mode == 3'd4) a = bv + (iv << size);
        else begin
            case (mode)
                3'd0: a = sp_val;
                3'd1: a = dp_val;
                3'd2: a = cp_val;
                default: a = bv;
            endcase
            a = a + 32'(imm) * 4;
        end
        if (mode > 3'd4) code = 3;
        else if (mode == 3'd4) begin
            if (ext || size == 2'd3) code = 3;
        end else begin
            lim = ext ? 16383 : ((mode == 3'd3) ? 11 : 63);
            if (size != 2'd2 || int'(imm) > lim) code = 3;
        end
        if (code == 0 && mode == 3'd2 && wr) code = 1;
        if (code == 0 && ((size == 2'd2 && a[1:0] != 2'b00) || (size == 2'd1 && a[0]))) code = 2;

        @(negedge clk);
        chk(req_ready && !mem_en && !rsp_valid && !exc_valid, {tag, " R9 idle before request"},
            {28'h0, req_ready, mem_en, rsp_valid, exc_valid}, 32'h8);
        req_mode = mode; req_ext = ext; req_write = wr; req_size = size; req_sext = sx;
        req_imm = imm; base_val = bv; index_val = iv; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (code != 0) begin
            chk(exc_valid && !mem_en && !req_ready, {tag, " exc_valid/no access"},
                {30'h0, exc_valid, mem_en}, 32'h2);
            chk(exc_code == 2'(code), {tag, " exc_code"}, 32'(exc_code), 32'(code));
        end else begin
            chk(mem_en && mem_we == wr && !req_ready && !exc_valid, {tag, " R9 access cycle"},
                {29'h0, mem_en, mem_we, exc_valid}, {29'h0, 1'b1, wr, 1'b0});
            chk(mem_addr == a, {tag, " address"}, mem_addr, a);
            if (wr) begin
                case (size)
                    2'd0: begin exp_be = 4'b0001 << a[1:0]; exp_wd = {4{wd[7:0]}}; end
                    2'd1: begin exp_be = 4'b0011 << a[1:0]; exp_wd = {2{wd[15:0]}}; end
                    default: begin exp_be = 4'hF; exp_wd = wd; end
                endcase
                chk(mem_be == exp_be, {tag, " R10 byte enables"}, 32'(mem_be), 32'(exp_be));
                chk(mem_wdata == exp_wd, {tag, " R10 write data"}, mem_wdata, exp_wd);
            end else begin
                @(negedge clk);
                sh = int'(a[1:0]) * 8;
                w = mem[a[9:2]] >> sh;
                case (size)
                    2'd0: exp_rd = sx ? {{24{w[7]}}, w[7:0]} : {24'h0, w[7:0]};
                    2'd1: exp_rd = sx ? {{16{w[15]}}, w[15:0]} : {16'h0, w[15:0]};
                    default: exp_rd = w;
                endcase
                chk(rsp_valid && !exc_valid, {tag, " R9 reply valid"}, 32'(rsp_valid), 32'h1);
                chk(rsp_data == exp_rd, {tag, " load data"}, rsp_data, exp_rd);
            end
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_en && !rsp_valid && !exc_valid, "R1 reset state",
            {28'h0, req_ready, mem_en, rsp_valid, exc_valid}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_en && !rsp_valid && !exc_valid, "R1 after reset release",
            {28'h0, req_ready, mem_en, rsp_valid, exc_valid}, 32'h8);

        // R2 pointer forms, limits 0 and 63
        do_req(3'd0, 0, 1, 2'd2, 0, 16'd5,  0, 0, 32'hCAFE_0005, "R2 stack write");
        do_req(3'd0, 0, 0, 2'd2, 0, 16'd5,  0, 0, 0, "R2 stack read");
        do_req(3'd1, 0, 1, 2'd2, 0, 16'd63, 0, 0, 32'h1234_5678, "R2 data write imm63");
        do_req(3'd1, 0, 0, 2'd2, 0, 16'd63, 0, 0, 0, "R2 data read imm63");
        do_req(3'd1, 0, 0, 2'd2, 0, 16'd64, 0, 0, 0, "R6 data imm64");
        do_req(3'd2, 0, 0, 2'd2, 0, 16'd0,  0, 0, 0, "R2 constant read");
        // R7 refused constant write, memory untouched
        do_req(3'd2, 0, 1, 2'd2, 0, 16'd7,  0, 0, 32'hDEAD_BEEF, "R7 constant write");
        do_req(3'd2, 0, 0, 2'd2, 0, 16'd7,  0, 0, 0, "R7 constant read after refused write");
        // R3 register short form
        do_req(3'd3, 0, 1, 2'd2, 0, 16'd11, 32'h80, 0, 32'h0BAD_F00D, "R3 reg write imm11");
        do_req(3'd3, 0, 0, 2'd2, 0, 16'd11, 32'h80, 0, 0, "R3 reg read imm11");
        do_req(3'd3, 0, 0, 2'd2, 0, 16'd12, 32'h80, 0, 0, "R6 reg imm12");
        // R6 other form faults
        do_req(3'd0, 0, 0, 2'd0, 0, 16'd1,  0, 0, 0, "R6 stack byte size");
        do_req(3'd4, 0, 0, 2'd3, 0, 16'd0,  32'h40, 0, 0, "R6 indexed size3");
        do_req(3'd4, 1, 0, 2'd2, 0, 16'd0,  32'h40, 0, 0, "R6 indexed with ext");
        do_req(3'd6, 0, 0, 2'd2, 0, 16'd0,  32'h40, 0, 0, "R6 mode6");
        // R4 indexed, R10 lanes, R11 zero ext, R12 sign ext
        do_req(3'd4, 0, 1, 2'd2, 0, 16'd0,  32'h40, 32'd0, 32'h80FF_7F81, "R4 indexed word write");
        for (int i = 0; i < 4; i++) begin
            do_req(3'd4, 0, 0, 2'd0, 0, 16'd0, 32'h40, 32'(i), 0, "R11 byte zero-ext");
            do_req(3'd4, 0, 0, 2'd0, 1, 16'd0, 32'h40, 32'(i), 0, "R12 byte sign-ext");
        end
        for (int i = 0; i < 2; i++) begin
            do_req(3'd4, 0, 0, 2'd1, 0, 16'd0, 32'h40, 32'(i), 0, "R11 half zero-ext");
            do_req(3'd4, 0, 0, 2'd1, 1, 16'd0, 32'h40, 32'(i), 0, "R12 half sign-ext");
        end
        do_req(3'd4, 0, 0, 2'd2, 1, 16'd0, 32'h40, 32'd0, 0, "R12 word sext no effect");
        for (int i = 0; i < 4; i++)
            do_req(3'd4, 0, 1, 2'd0, 0, 16'd0, 32'h50, 32'(i), 32'(8'h11 * (i + 1)), "R10 byte lane write");
        do_req(3'd4, 0, 0, 2'd2, 0, 16'd0, 32'h50, 32'd0, 0, "R10 lanes read back");
        do_req(3'd4, 0, 1, 2'd1, 0, 16'd0, 32'h60, 32'd1, 32'h0000_A5C3, "R10 half write upper");
        do_req(3'd4, 0, 0, 2'd2, 0, 16'd0, 32'h60, 32'd0, 0, "R4 half write read back");
        // R8 misalignment and priority
        do_req(3'd4, 0, 0, 2'd1, 0, 16'd0, 32'h41, 32'd0, 0, "R8 half odd");
        do_req(3'd4, 0, 0, 2'd2, 0, 16'd0, 32'h42, 32'd0, 0, "R8 word off by 2");
        do_req(3'd4, 0, 0, 2'd0, 0, 16'd0, 32'h43, 32'd0, 0, "R8 byte any alignment");
        sp_val = 32'h102;
        do_req(3'd0, 0, 0, 2'd2, 0, 16'd1, 0, 0, 0, "R8 unaligned stack pointer");
        sp_val = 32'h100;
        do_req(3'd2, 0, 1, 2'd2, 0, 16'd64, 0, 0, 0, "R8 priority form over read-only");
        cp_val = 32'h301;
        do_req(3'd2, 0, 1, 2'd2, 0, 16'd1, 0, 0, 0, "R8 priority read-only over align");
        cp_val = 32'h300;
        // R5 extended range
        do_req(3'd0, 1, 1, 2'd2, 0, 16'd100,   0, 0, 32'h5555_AAAA, "R5 ext write imm100");
        do_req(3'd0, 1, 0, 2'd2, 0, 16'd100,   0, 0, 0, "R5 ext read imm100");
        do_req(3'd3, 1, 0, 2'd2, 0, 16'd16383, 32'h0, 0, 0, "R5 ext reg imm16383");
        do_req(3'd1, 1, 0, 2'd2, 0, 16'd16384, 0, 0, 0, "R5 ext imm16384");
        @(negedge clk);
        chk(req_ready && !mem_en && !rsp_valid && !exc_valid, "R9 idle at end",
            {28'h0, req_ready, mem_en, rsp_valid, exc_valid}, 32'h8);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule